// File: doc/BRIEF.md
# Inter-VM Doorbell Register Interface

This block is the small register window of a shared-memory device that links several virtual machines. Software in the local VM sees four 32-bit registers in a 256-byte window. An interrupt enable mask and an event status word are both fully writable. The status word empties itself when it is read. A read-only identity register returns the number that was given to this VM. The last register takes doorbell writes, and each doorbell write asks the block to signal a peer VM on one of that peer's vectors.

A doorbell write carries a 16-bit peer number in its upper half and an 8-bit vector number in its low byte. The block compares the peer number with the current peer count. It also compares the vector number with the number of vectors that peer has registered, which an external synchronous table returns. Only a doorbell that passes both checks leaves the block, as a one-cycle notify pulse that carries the peer and the vector. A doorbell that fails either check disappears without any trace.

Events that arrive for the local VM follow a mode input. In legacy mode an event sets the status word to 1, and a level interrupt follows the masked status. In message mode the event leaves again as a one-cycle message pulse on its own vector, and the status word stays untouched.

Top module: `vm_doorbell_regs`

## Requirements
- R1: After a synchronous reset the mask and the status word read as zero. The irq, notify, message and read-valid outputs are low.
- R2: A write at offset 0x00 replaces the mask and a write at offset 0x04 replaces the status word with all 32 data bits. A read at the same offset returns the new value in the response that follows the read.
- R3: A read at offset 0x04 returns the status word as it was before the read and clears it to zero in that same cycle. A second read then returns zero.
- R4: A read at offset 0x08 returns `self_id` zero-extended to 32 bits. A read at 0x0C, at any other offset, or at an address whose bits 1:0 are not zero returns zero. Read data appears, together with `rsp_valid`, in the cycle after the request.
- R5: A write is decoded on its address with bits 1:0 forced to zero (address AND 0xFC). Writes at 0x08 or at an undefined offset change no register.
- R6: A doorbell write at offset 0x0C, with the peer in data bits 31:16 and the vector in data bits 7:0, raises `ntf_valid` for exactly one cycle, two cycles after the write. The pulse carries that peer and that vector. Data bits 15:8 have no effect.
- R7: A doorbell whose peer is equal to or above `peer_count` produces no notify pulse.
- R8: A doorbell whose vector is equal to or above the vector count that the table returns for its peer produces no notify pulse.
- R9: In legacy mode (`msi_mode`=0) an event sets the status word to 1. The event wins over a status read or a status write in the same cycle, and that read still returns the old value.
- R10: In message mode (`msi_mode`=1) an event raises `msi_valid` for one cycle in the next cycle, with its vector on `msi_vector`, and leaves the status word unchanged.
- R11: `irq` is high in the cycle after one in which (status AND mask) is nonzero, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address in the register window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, zero when no read |
| self_id | input | 16 | Identity of this VM |
| peer_count | input | 17 | Number of valid peers |
| tbl_peer | output | 16 | Peer index presented to the vector-count table |
| tbl_count | input | 9 | Vector count, one cycle after tbl_peer |
| evt_valid | input | 1 | Incoming event for this VM |
| evt_vector | input | 8 | Vector of the incoming event |
| msi_mode | input | 1 | 1 = forward events as messages |
| irq | output | 1 | Legacy level interrupt |
| msi_valid | output | 1 | Message pulse |
| msi_vector | output | 8 | Vector of the message pulse |
| ntf_valid | output | 1 | Notify pulse to a peer |
| ntf_peer | output | 16 | Destination peer of the notify |
| ntf_vector | output | 8 | Destination vector of the notify |

## Verification
The checks assume that the vector-count table is a synchronous memory that answers one cycle after `tbl_peer` is presented. They also assume that `peer_count` and the table contents stay fixed while a doorbell is in flight, and that inputs never change at a clock edge. The stimulus keeps to these assumptions: it fills the table and sets the peer count once before reset is released, and it drives every request and event on the falling edge. Each cycle carries at most one register access, and the bench combines that access with an event only when it targets the same-cycle priority between an event and a read or write of the status word.

// File: rtl/vdb_pkg.sv
package vdb_pkg;
  localparam int WIN_AW = 8;

  localparam logic [WIN_AW-1:0] OFS_MASK = 8'h00;
  localparam logic [WIN_AW-1:0] OFS_STAT = 8'h04;
  localparam logic [WIN_AW-1:0] OFS_POS  = 8'h08;
  localparam logic [WIN_AW-1:0] OFS_BELL = 8'h0C;
  localparam logic [WIN_AW-1:0] WR_ALIGN = 8'hFC;

  typedef enum logic [2:0] {
    SEL_MASK,
    SEL_STAT,
    SEL_POS,
    SEL_BELL,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [WIN_AW-1:0] a);
    case (a)
      OFS_MASK: return SEL_MASK;
      OFS_STAT: return SEL_STAT;
      OFS_POS:  return SEL_POS;
      OFS_BELL: return SEL_BELL;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/vdb_regfile.sv
module vdb_regfile
  import vdb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_sel_e          wr_sel,
  input  logic              rd_en,
  input  reg_sel_e          rd_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ID_W-1:0]   self_id,
  input  logic              set_evt,
  output logic              rvalid_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              irq_q
);
  localparam int PAD_W = DATA_W - ID_W;

  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_stat;
  logic              rd_stat;

  assign wr_stat = wr_en && (wr_sel == SEL_STAT);
  assign rd_stat = rd_en && (rd_sel == SEL_STAT);

  always_comb begin
    case (rd_sel)
      SEL_MASK: rd_mux = mask_q;
      SEL_STAT: rd_mux = status_q;
      SEL_POS:  rd_mux = {{PAD_W{1'b0}}, self_id};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (wr_en && (wr_sel == SEL_MASK)) begin
      mask_q <= wdata;
    end
  end

  // Priority: incoming event, then software write, then clear on read.
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
    end else if (set_evt) begin
      status_q <= DATA_W'(1);
    end else if (wr_stat) begin
      status_q <= wdata;
    end else if (rd_stat) begin
      status_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      rdata_q  <= rd_en ? rd_mux : '0;
      irq_q    <= |(mask_q & status_q);
    end
  end

  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !set_evt && !wr_stat) |=> (status_q == '0));

  assert_event_R9: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> (status_q == DATA_W'(1)));

  assert_mask_R11: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_q);
endmodule

// File: rtl/vdb_doorbell.sv
module vdb_doorbell #(
  parameter int DATA_W = 32,
  parameter int PEER_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bell_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PEER_W:0]   peer_count,
  output logic [PEER_W-1:0] tbl_peer,
  input  logic [VEC_W:0]    tbl_count,
  output logic              ntf_valid,
  output logic [PEER_W-1:0] ntf_peer,
  output logic [VEC_W-1:0]  ntf_vec
);
  localparam int PEER_LSB = DATA_W - PEER_W;

  logic [PEER_W-1:0] wr_peer;
  logic [VEC_W-1:0]  wr_vec;
  logic              s1_valid;
  logic [PEER_W-1:0] s1_peer;
  logic [VEC_W-1:0]  s1_vec;

  assign wr_peer  = wdata[PEER_LSB +: PEER_W];
  assign wr_vec   = wdata[VEC_W-1:0];
  assign tbl_peer = wr_peer;

  // Stage 1: peer range check while the table read is in flight.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_peer  <= '0;
      s1_vec   <= '0;
    end else begin
      s1_valid <= bell_wr && ({1'b0, wr_peer} < peer_count);
      s1_peer  <= wr_peer;
      s1_vec   <= wr_vec;
    end
  end

  // Stage 2: vector range check against the returned count.
  always_ff @(posedge clk) begin
    if (rst) begin
      ntf_valid <= 1'b0;
      ntf_peer  <= '0;
      ntf_vec   <= '0;
    end else begin
      ntf_valid <= s1_valid && ({1'b0, s1_vec} < tbl_count);
      ntf_peer  <= s1_peer;
      ntf_vec   <= s1_vec;
    end
  end

  assert_origin_R6: assert property (@(posedge clk) disable iff (rst)
    ntf_valid |-> $past(bell_wr, 2));

  assert_peer_R7: assert property (@(posedge clk) disable iff (rst)
    ntf_valid |-> ({1'b0, ntf_peer} < $past(peer_count, 2)));

  assert_vec_R8: assert property (@(posedge clk) disable iff (rst)
    ntf_valid |-> ({1'b0, ntf_vec} < $past(tbl_count)));
endmodule

// File: rtl/vdb_event.sv
module vdb_event #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_valid,
  input  logic [VEC_W-1:0] evt_vector,
  input  logic             msi_mode,
  output logic             set_status,
  output logic             msi_valid_q,
  output logic [VEC_W-1:0] msi_vector_q
);
  assign set_status = evt_valid && !msi_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      msi_valid_q  <= 1'b0;
      msi_vector_q <= '0;
    end else begin
      msi_valid_q  <= evt_valid && msi_mode;
      msi_vector_q <= evt_vector;
    end
  end

  assert_fwd_R10: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && msi_mode) |=> msi_valid_q);

  assert_only_msi_R10: assert property (@(posedge clk) disable iff (rst)
    msi_valid_q |-> ($past(msi_mode) && $past(evt_valid)));
endmodule

// File: rtl/vm_doorbell_regs.sv
module vm_doorbell_regs
  import vdb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PEER_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [WIN_AW-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [PEER_W-1:0] self_id,
  input  logic [PEER_W:0]   peer_count,
  output logic [PEER_W-1:0] tbl_peer,
  input  logic [VEC_W:0]    tbl_count,
  input  logic              evt_valid,
  input  logic [VEC_W-1:0]  evt_vector,
  input  logic              msi_mode,
  output logic              irq,
  output logic              msi_valid,
  output logic [VEC_W-1:0]  msi_vector,
  output logic              ntf_valid,
  output logic [PEER_W-1:0] ntf_peer,
  output logic [VEC_W-1:0]  ntf_vector
);
  logic     wr_en;
  logic     rd_en;
  reg_sel_e wr_sel;
  reg_sel_e rd_sel;
  logic     set_evt;

  assign wr_en  = req_valid && req_write;
  assign rd_en  = req_valid && !req_write;
  assign wr_sel = decode_ofs(req_addr & WR_ALIGN);
  assign rd_sel = decode_ofs(req_addr);

  vdb_event #(.VEC_W(VEC_W)) u_event (
    .clk          (clk),
    .rst          (rst),
    .evt_valid    (evt_valid),
    .evt_vector   (evt_vector),
    .msi_mode     (msi_mode),
    .set_status   (set_evt),
    .msi_valid_q  (msi_valid),
    .msi_vector_q (msi_vector)
  );

  vdb_regfile #(.DATA_W(DATA_W), .ID_W(PEER_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .rd_en    (rd_en),
    .rd_sel   (rd_sel),
    .wdata    (req_wdata),
    .self_id  (self_id),
    .set_evt  (set_evt),
    .rvalid_q (rsp_valid),
    .rdata_q  (rsp_rdata),
    .irq_q    (irq)
  );

  vdb_doorbell #(.DATA_W(DATA_W), .PEER_W(PEER_W), .VEC_W(VEC_W)) u_bell (
    .clk        (clk),
    .rst        (rst),
    .bell_wr    (wr_en && (wr_sel == SEL_BELL)),
    .wdata      (req_wdata),
    .peer_count (peer_count),
    .tbl_peer   (tbl_peer),
    .tbl_count  (tbl_count),
    .ntf_valid  (ntf_valid),
    .ntf_peer   (ntf_peer),
    .ntf_vec    (ntf_vector)
  );

  assert_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (ntf_valid && $past(ntf_valid)) |-> $past(wr_en && (wr_sel == SEL_BELL), 2));
endmodule

// File: tb/test_vm_doorbell_regs.sv
module test_vm_doorbell_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [15:0] self_id = 16'h0003;
  logic [16:0] peer_count = 17'd5;
  logic [15:0] tbl_peer;
  logic [8:0]  tbl_count = '0;
  logic        evt_valid = 1'b0;
  logic [7:0]  evt_vector = '0;
  logic        msi_mode = 1'b0;
  logic        irq, msi_valid, ntf_valid;
  logic [7:0]  msi_vector, ntf_vector;
  logic [15:0] ntf_peer;

  int checks = 0;
  int fails = 0;
  string ctx = "R1";
  bit seen = 0;
  bit done = 0;

  int vtab [8] = '{2, 1, 0, 4, 3, 7, 7, 7};

  always #4 clk = ~clk;

  // External synchronous vector-count table.
  always @(posedge clk) tbl_count <= (tbl_peer < 16'd8) ? 9'(vtab[tbl_peer]) : 9'd0;

  vm_doorbell_regs i_vm_doorbell_regs (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .self_id(self_id), .peer_count(peer_count),
    .tbl_peer(tbl_peer), .tbl_count(tbl_count), .evt_valid(evt_valid),
    .evt_vector(evt_vector), .msi_mode(msi_mode), .irq(irq),
    .msi_valid(msi_valid), .msi_vector(msi_vector), .ntf_valid(ntf_valid),
    .ntf_peer(ntf_peer), .ntf_vector(ntf_vector)
  );

  // Behavioural reference model.
  logic [31:0] m_mask, m_status, e_rdata;
  bit e_rvalid, e_irq, e_msi_v, e_ntf_v, d_v;
  int e_msi_x, e_ntf_p, e_ntf_x, d_p, d_x;

  always @(posedge clk) begin
    if (rst) begin
      m_mask = 0; m_status = 0; e_rdata = 0; e_rvalid = 0; e_irq = 0;
      e_msi_v = 0; e_ntf_v = 0; d_v = 0;
    end else begin
      int peer, vec, cnt;
      bit wr, rd;
      logic [7:0] wa;
      wr = req_valid && req_write;
      rd = req_valid && !req_write;
      wa = req_addr & 8'hFC;
      e_ntf_v = d_v; e_ntf_p = d_p; e_ntf_x = d_x;
      peer = int'(req_wdata[31:16]);
      vec = int'(req_wdata[7:0]);
      cnt = (peer < 8) ? vtab[peer] : 0;
      d_v = wr && (wa == 8'h0C) && (peer < int'(peer_count)) && (vec < cnt);
      d_p = peer; d_x = vec;
      e_irq = (m_status & m_mask) != 0;
      e_rvalid = rd;
      e_rdata = 0;
      if (rd) begin
        if (req_addr == 8'h00) e_rdata = m_mask;
        else if (req_addr == 8'h04) e_rdata = m_status;
        else if (req_addr == 8'h08) e_rdata = {16'h0, self_id};
      end
      e_msi_v = evt_valid && msi_mode;
      e_msi_x = int'(evt_vector);
      if (wr && wa == 8'h00) m_mask = req_wdata;
      if (evt_valid && !msi_mode) m_status = 1;
      else if (wr && wa == 8'h04) m_status = req_wdata;
      else if (rd && req_addr == 8'h04) m_status = 0;
    end
    seen = 1;
  end

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", ctx, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (seen && !done) begin
      chk(rsp_valid == e_rvalid, "rsp_valid", rsp_valid, e_rvalid);
      chk(rsp_rdata == e_rdata, "rsp_rdata", rsp_rdata, e_rdata);
      chk(irq == e_irq, "irq", irq, e_irq);
      chk(msi_valid == e_msi_v, "msi_valid", msi_valid, e_msi_v);
      if (e_msi_v) chk(int'(msi_vector) == e_msi_x, "msi_vector", msi_vector, e_msi_x);
      chk(ntf_valid == e_ntf_v, "ntf_valid", ntf_valid, e_ntf_v);
      if (e_ntf_v) begin
        chk(int'(ntf_peer) == e_ntf_p, "ntf_peer", ntf_peer, e_ntf_p);
        chk(int'(ntf_vector) == e_ntf_x, "ntf_vector", ntf_vector, e_ntf_x);
      end
    end
  end

  task automatic step(bit v, bit w, logic [7:0] a, logic [31:0] d,
                      bit ev, logic [7:0] evv, bit mm);
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    evt_valid = ev; evt_vector = evv; msi_mode = mm;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d); step(1, 1, a, d, 0, 0, 0); endtask
  task automatic rd(logic [7:0] a); step(1, 0, a, 0, 0, 0, 0); endtask
  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic bell(int p, int x, logic [7:0] junk);
    step(1, 1, 8'h0C, {16'(p), junk, 8'(x)}, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ctx = "R1"; rd(8'h00); rd(8'h04); idle();
    ctx = "R2"; wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hA5A5_0003); rd(8'h00);
    ctx = "R3"; rd(8'h04); rd(8'h04); idle();
    ctx = "R11"; wr(8'h00, 32'h0000_0001); wr(8'h04, 32'h0000_0002); idle(); idle();
    wr(8'h04, 32'h0000_0001); idle(); idle(); rd(8'h04); idle(); idle();
    ctx = "R4"; rd(8'h08); rd(8'h0C); rd(8'h10); rd(8'h01); rd(8'hFC); rd(8'h0B); idle();
    ctx = "R5"; wr(8'h03, 32'h0000_1234); rd(8'h00); wr(8'h08, 32'hDEAD_BEEF);
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h06, 32'h0000_00F0); rd(8'h08); rd(8'h00); rd(8'h04);
    idle();
    ctx = "R6"; bell(0, 1, 8'hFF); idle(); idle(); bell(3, 3, 8'h5A); bell(4, 2, 8'h00);
    bell(1, 0, 8'h80); idle(); step(1, 1, 8'h0E, {16'd0, 8'h00, 8'h00}, 0, 0, 0);
    idle(); idle();
    ctx = "R7"; bell(5, 0, 8'h00); bell(16'hFFFF, 0, 8'h00); bell(7, 0, 8'h00); idle(); idle();
    ctx = "R8"; bell(0, 2, 8'h00); bell(2, 0, 8'h00); bell(3, 4, 8'h00); bell(3, 255, 8'h00);
    idle(); idle();
    ctx = "R9"; wr(8'h04, 32'h0); wr(8'h00, 32'hFFFF_FFFF); step(0, 0, 0, 0, 1, 8'd4, 0);
    idle(); rd(8'h04); step(1, 0, 8'h04, 0, 1, 8'd1, 0); rd(8'h04);
    step(1, 1, 8'h04, 32'h0000_00F0, 1, 8'd0, 0); rd(8'h04); idle();
    ctx = "R10"; wr(8'h04, 32'h0000_0000); step(0, 0, 0, 0, 1, 8'd7, 1);
    step(0, 0, 0, 0, 1, 8'd200, 1); idle(); rd(8'h04); step(0, 0, 0, 0, 1, 8'd3, 1);
    idle(); idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule